// File: doc/BRIEF.md
# Modbus RTU CRC-16 Engine

This block computes the 16-bit checksum used on Modbus RTU serial frames. Bytes arrive through a valid/ready handshake. Each accepted byte is folded into a reflected 16-bit register that shifts right, and the engine does one bit of that work per clock. A clear input starts a new message by loading the register with all ones.

A finish request hands the current remainder to a small serialiser. The serialiser presents the checksum in line order, low byte first, through a second valid/ready handshake.

For reception, the whole frame is fed through the engine, including its two trailing checksum bytes. The zero flag then reports whether the remainder is zero, which marks an intact frame. The serial line itself and the inter-frame gap timing belong to neighbouring logic.

Top module: `mbcrc_engine`

## Requirements
- R1: After reset, and in the cycle after `clear` is sampled high, `crc_out` is FFFF (hex), `in_ready` is 1 and `tx_valid` is 0.
- R2: A byte is accepted on a rising edge where `in_valid` and `in_ready` are both high and `clear` is low. `in_ready` then stays low for exactly 8 cycles.
- R3: Once its 8 cycles have passed, an accepted byte has updated the register as follows. The byte is XORed into bits 7:0. Then, eight times over, the register shifts right with a 0 entering bit 15, and A001 (hex) is XORed in whenever the bit shifted out was 1.
- R4: After a clear, the nine ASCII bytes "123456789" (31 to 39 hex) leave `crc_out` equal to 4B37 (hex).
- R5: A finish request is taken only on an edge where the engine is idle and `in_valid` is low. `in_valid` has precedence when both are raised. After a taken request, `tx_valid` rises and `tx_data` shows `crc_out[7:0]`, then `crc_out[15:8]`. Each byte is held until it is taken on an edge with `tx_ready` high, and `in_ready` stays low while bytes are pending.
- R6: `crc_zero` is 1 exactly when no byte is being shifted and `crc_out` is 0000. A frame followed by its own checksum, low byte first, sets it; a frame with a corrupted checksum byte does not.
- R7: `clear` has priority over everything else. A byte in mid-shift is discarded, and a byte offered in the same cycle as `clear` is not accepted.
- R8: A finish request raised while a byte is still being shifted is ignored: no checksum byte is presented because of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Start a new message (preset register, abort work) |
| in_valid | input | 1 | Input byte offered |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Engine can take a byte |
| fin_req | input | 1 | Request serialisation of the current checksum |
| crc_out | output | 16 | Current register contents |
| crc_zero | output | 1 | Idle with zero remainder (check result) |
| tx_valid | output | 1 | Checksum byte presented |
| tx_data | output | 8 | Checksum byte, low byte first |
| tx_ready | input | 1 | Consumer takes the presented byte |

## Verification
The hardest state to reach from the ports is a `clear` that lands in the middle of a byte's eight shift cycles while a new byte is also being offered. The bench reaches it by raising `clear` and `in_valid` together in the cycle just after a byte is accepted. It then confirms that the register is back at its preset and that the offered byte was dropped.

A second awkward case is a serialiser stalled by `tx_ready` while the byte input is still being driven. This arises during the random phase, which mixes byte bursts and finish requests with random `tx_ready` stalls. A behavioural model compares the outputs against the design on every clock.

// File: rtl/mbcrc_engine.sv
module mbcrc_engine #(
  parameter int CRC_W = 16,
  parameter int BYTE_W = 8,
  parameter logic [CRC_W-1:0] POLY = 16'hA001,
  parameter logic [CRC_W-1:0] INIT = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  input  logic              fin_req,
  output logic [CRC_W-1:0]  crc_out,
  output logic              crc_zero,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready
);
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam int NBYTES = CRC_W / BYTE_W;
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic [CRC_W-1:0] crc;
  logic [CNT_W-1:0] bits_left;
  logic             tx_busy;
  logic [IDX_W-1:0] tx_idx;

  logic             idle, take, start_tx, tx_last;
  logic [CRC_W-1:0] shifted;

  assign idle     = (bits_left == '0) && !tx_busy;
  assign take     = in_valid && idle;
  assign start_tx = fin_req && idle && !in_valid;
  assign tx_last  = (tx_idx == IDX_W'(NBYTES - 1));
  assign shifted  = {1'b0, crc[CRC_W-1:1]} ^ (crc[0] ? POLY : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc       <= INIT;
      bits_left <= '0;
      tx_busy   <= 1'b0;
      tx_idx    <= '0;
    end else if (clear) begin
      crc       <= INIT;
      bits_left <= '0;
      tx_busy   <= 1'b0;
      tx_idx    <= '0;
    end else begin
      if (bits_left != '0) begin
        crc       <= shifted;
        bits_left <= bits_left - 1'b1;
      end else if (take) begin
        crc       <= crc ^ CRC_W'(in_data);
        bits_left <= CNT_W'(BYTE_W);
      end
      if (start_tx) begin
        tx_busy <= 1'b1;
        tx_idx  <= '0;
      end else if (tx_busy && tx_ready) begin
        if (tx_last) begin
          tx_busy <= 1'b0;
          tx_idx  <= '0;
        end else begin
          tx_idx <= tx_idx + 1'b1;
        end
      end
    end
  end

  assign in_ready = idle;
  assign crc_out  = crc;
  assign crc_zero = (bits_left == '0) && (crc == '0);
  assign tx_valid = tx_busy;
  assign tx_data  = BYTE_W'(crc >> (int'(tx_idx) * BYTE_W));
endmodule

module mbcrc_engine_chk #(
  parameter int CRC_W = 16,
  parameter int BYTE_W = 8,
  parameter logic [CRC_W-1:0] INIT = 16'hFFFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clear,
  input logic              in_valid,
  input logic              in_ready,
  input logic              fin_req,
  input logic [CRC_W-1:0]  crc_out,
  input logic              crc_zero,
  input logic              tx_valid,
  input logic [BYTE_W-1:0] tx_data,
  input logic              tx_ready
);
  // R1
  clear_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (crc_out == INIT) && in_ready && !tx_valid);

  // R2
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !clear) |=> !in_ready);

  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !clear) |=> tx_valid && $stable(tx_data));

  // R5
  tx_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !in_ready);

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crc_zero |-> (crc_out == '0));

  // R8
  busy_finish_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_req && !in_ready && !tx_valid && !clear) |=> !tx_valid);
endmodule

bind mbcrc_engine mbcrc_engine_chk #(.CRC_W(CRC_W), .BYTE_W(BYTE_W), .INIT(INIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid), .in_ready(in_ready),
  .fin_req(fin_req), .crc_out(crc_out), .crc_zero(crc_zero), .tx_valid(tx_valid),
  .tx_data(tx_data), .tx_ready(tx_ready)
);

// File: tb/sim_mbcrc_engine.sv
`timescale 1ns/1ps
module sim_mbcrc_engine;
  logic clk = 0, rst_n = 0, clear = 0, in_valid = 0, fin_req = 0, tx_ready = 0;
  logic [7:0] in_data = 0;
  logic in_ready, crc_zero, tx_valid;
  logic [15:0] crc_out;
  logic [7:0] tx_data;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mbcrc_engine u0 (.clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .fin_req(fin_req), .crc_out(crc_out),
    .crc_zero(crc_zero), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready));

  function automatic logic [15:0] ref_byte(logic [15:0] c, logic [7:0] b);
    c = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
    return c;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // behavioural model
  logic [15:0] m_crc = 16'hFFFF;
  int m_cnt = 0, m_ser = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_crc = 16'hFFFF; m_cnt = 0; m_ser = 0;
    end else if (clear) begin
      m_crc = 16'hFFFF; m_cnt = 0; m_ser = 0;
    end else if (m_cnt > 0) begin
      m_cnt--;
    end else if (m_ser != 0) begin
      if (tx_ready) m_ser = (m_ser == 1) ? 2 : 0;
    end else if (in_valid) begin
      m_crc = ref_byte(m_crc, in_data); m_cnt = 8;
    end else if (fin_req) begin
      m_ser = 1;
    end
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      finish_run();
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R2 in_ready", in_ready, (m_cnt == 0 && m_ser == 0));
    chk("R5 tx_valid", tx_valid, (m_ser != 0));
    if (m_ser != 0) chk("R5 tx_data", tx_data, (m_ser == 1) ? m_crc[7:0] : m_crc[15:8]);
    if (m_cnt == 0) begin
      chk("R3 crc_out", crc_out, m_crc);
      chk("R6 crc_zero", crc_zero, (m_crc == 16'h0));
    end
  end

  task automatic send_byte(logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = b;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wait_idle();
    while (!in_ready) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1;
    @(negedge clk); clear = 0;
  endtask

  task automatic collect(output logic [7:0] lo, output logic [7:0] hi);
    int got = 0;
    @(negedge clk); wait_idle();
    fin_req = 1;
    @(negedge clk); fin_req = 0;
    while (got < 2) begin
      tx_ready = ($urandom % 3) != 0;
      if (tx_valid && tx_ready) begin
        if (got == 0) lo = tx_data; else hi = tx_data;
        got++;
      end
      @(negedge clk);
    end
    tx_ready = 0;
  endtask

  task automatic send_digits();
    for (int i = 0; i < 9; i++) send_byte(8'h31 + 8'(i));
  endtask

  initial begin
    logic [7:0] lo, hi;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 crc_out reset", crc_out, 16'hFFFF);
    chk("R1 in_ready reset", in_ready, 1);
    chk("R1 tx_valid reset", tx_valid, 0);

    // R2 ready low for 8 cycles
    send_byte(8'hA5);
    n = 0;
    while (!in_ready) begin n++; @(negedge clk); end
    chk("R2 busy cycles", n, 8);

    // R4 known string
    do_clear();
    send_digits();
    wait_idle();
    chk("R4 check value", crc_out, 16'h4B37);

    // R5 serialiser order
    collect(lo, hi);
    chk("R5 first byte", lo, 8'h37);
    chk("R5 second byte", hi, 8'h4B);

    // R6 good frame
    do_clear();
    send_digits();
    send_byte(8'h37); send_byte(8'h4B);
    wait_idle();
    chk("R6 good frame zero", crc_zero, 1);
    // R6 corrupted frame
    do_clear();
    send_digits();
    send_byte(8'h37); send_byte(8'h4C);
    wait_idle();
    chk("R6 bad frame nonzero", crc_zero, 0);

    // R7 clear mid-byte with byte offered
    do_clear();
    send_byte(8'h12);
    clear = 1; in_valid = 1; in_data = 8'h99;
    @(negedge clk);
    clear = 0; in_valid = 0;
    chk("R7 crc preset", crc_out, 16'hFFFF);
    chk("R7 ready after clear", in_ready, 1);
    @(negedge clk);
    chk("R7 byte dropped", crc_out, 16'hFFFF);

    // R8 finish while shifting ignored
    send_byte(8'h5A);
    fin_req = 1;
    @(negedge clk); fin_req = 0;
    wait_idle();
    chk("R8 no tx", tx_valid, 0);
    repeat (2) @(negedge clk);
    chk("R8 still no tx", tx_valid, 0);

    // R5 byte wins over simultaneous finish
    @(negedge clk);
    in_valid = 1; in_data = 8'h3C; fin_req = 1;
    @(negedge clk);
    in_valid = 0; fin_req = 0;
    chk("R5 byte precedence", in_ready, 0);
    wait_idle();
    chk("R5 no tx after tie", tx_valid, 0);

    // random mix, model compared every clock (R3 R5)
    for (int k = 0; k < 60; k++) begin
      if ($urandom % 6 == 0) collect(lo, hi);
      else if ($urandom % 15 == 0) do_clear();
      else begin
        send_byte(8'($urandom));
        repeat ($urandom % 3) @(negedge clk);
      end
    end
    wait_idle();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule